// File: doc/BRIEF.md
# SMBus Host Register Front End

This block is the software-visible register file of an SMBus host controller. It occupies a 64-byte window on a byte-wide register bus. Software fills in the target address, the command byte and the data bytes. It then writes the control register with the start bit set and a protocol code in bits 4:2. The block checks that code and, when it is valid, raises one request towards a byte-level bus engine. That request carries a frozen copy of every transfer argument.

While the request is outstanding, the status register shows the host as busy. When the engine acknowledges, the block returns any read data into the data registers. It then records success or failure in the status register. A 32-byte block buffer is reached by software through one auto-incrementing index. The engine reaches the same buffer through its own index port, so block transfers of up to 32 bytes can be staged and collected.

Top module: `smb_host_regs`

## Requirements
- R1: After reset, every register reads zero and `eng_req` is low.
- R2: Offsets 3 (command), 4 (target address), 5 (data0) and 6 (data1) read back the last byte written to them. Any offset other than 0, 2, 3, 4, 5, 6 and 7 reads zero.
- R3: A control write with bit 6 set and a protocol code of 0 (quick), 1 (send/receive byte), 2 (byte data), 3 (word data) or 5 (block) raises `eng_req` on the next cycle. The request presents the following, all held unchanged until acknowledge:
  - the code on `eng_proto`;
  - address bit 0 on `eng_rnw` (1 = read);
  - address bits 7:1 on `eng_taddr`;
  - the command register on `eng_cmd`;
  - data0 on `eng_d0`, which is also the byte count for a block transfer;
  - data1 on `eng_d1`.
- R4: Status bit 0 (busy) reads 1 while a request is outstanding. On the edge where `eng_ack` is sampled, busy clears and `eng_req` falls. At the same edge, status bit 1 (done) is set, or status bit 2 (error) is set instead if `eng_err` is high.
- R5: A start with code 4, 6 or 7 sets status bit 2 and raises no request.
- R6: A start written while busy launches nothing. The outstanding request and its arguments stay unchanged.
- R7: On completion of a read, the returned bytes go into the data registers as follows:
  - receive byte, byte data and block: `eng_rd0` goes into data0 (for a block read it is the count);
  - word data: `eng_rd0` goes into data0 and `eng_rd1` into data1.
  Write transfers and quick commands leave data0 and data1 unchanged.
- R8: Each read or write of offset 7 uses the buffer entry at the current index and then advances the index, which wraps from 31 to 0. The engine reads and writes the buffer through `eng_buf_idx`.
- R9: Any write to offset 0 clears the done and error bits and resets the buffer index. A read of offset 2 returns only control bits 4:0 and resets the buffer index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances side effects) |
| reg_ofs | input | 6 | Byte offset inside the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_ofs` (combinational) |
| eng_req | output | 1 | Transaction request to the bus engine |
| eng_proto | output | 3 | Protocol code of the request |
| eng_rnw | output | 1 | 1 = read transfer |
| eng_taddr | output | 7 | 7-bit target address |
| eng_cmd | output | 8 | Command / sent byte |
| eng_d0 | output | 8 | Data low byte or block count |
| eng_d1 | output | 8 | Data high byte |
| eng_ack | input | 1 | Engine completion, one cycle |
| eng_err | input | 1 | Completion failed (valid with `eng_ack`) |
| eng_rd0 | input | 8 | Returned low byte or block count |
| eng_rd1 | input | 8 | Returned high byte |
| eng_buf_idx | input | 5 | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Buffer byte at `eng_buf_idx` |

## Verification
The bench goes after four hazards:
- **Index wrap.** The buffer index is driven past 31 with 33 writes. A design that failed to wrap would lose the 33rd byte, so entry 0 would not hold it.
- **Index reset by reading control.** The bench reads the control register between block accesses. A design that skipped the index reset there would place the next byte at entry 2 instead of entry 0.
- **Start while busy.** A second start is issued during an outstanding word write. A design that relaunched would change `eng_proto` or raise a fresh request after the acknowledge.
- **Return-data placement.** Completions with read and write direction are compared. A design that mixed them up would overwrite data0/data1 on writes, or leave data1 stale on a word read.

// File: rtl/smb_host_pkg.sv
// Shared definitions for the SMBus host register front end.
// Holds the register offsets and the protocol code set; assumes a 3-bit code field.
package smb_host_pkg;

    localparam logic [5:0] OFS_STAT = 6'd0;
    localparam logic [5:0] OFS_CTRL = 6'd2;
    localparam logic [5:0] OFS_CMD  = 6'd3;
    localparam logic [5:0] OFS_TADR = 6'd4;
    localparam logic [5:0] OFS_D0   = 6'd5;
    localparam logic [5:0] OFS_D1   = 6'd6;
    localparam logic [5:0] OFS_BLK  = 6'd7;

    localparam logic [2:0] PC_QUICK = 3'd0;
    localparam logic [2:0] PC_BYTE  = 3'd1;
    localparam logic [2:0] PC_BDATA = 3'd2;
    localparam logic [2:0] PC_WORD  = 3'd3;
    localparam logic [2:0] PC_BLOCK = 3'd5;

    // True for the protocol codes the engine understands.
    function automatic logic proto_ok(input logic [2:0] code);
        return (code == PC_QUICK) || (code == PC_BYTE) || (code == PC_BDATA) ||
               (code == PC_WORD)  || (code == PC_BLOCK);
    endfunction

    // True for codes whose read completion returns data0 (data1 only for words).
    function automatic logic proto_returns(input logic [2:0] code);
        return (code == PC_BYTE) || (code == PC_BDATA) ||
               (code == PC_WORD) || (code == PC_BLOCK);
    endfunction

endpackage

// File: rtl/smb_blk_buf.sv
// Block transfer buffer with a software port and an engine port.
// Both ports read combinationally; when both write the same entry in one
// cycle the engine write wins. Assumes DEPTH is a power of two.
module smb_blk_buf #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 8,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [IW-1:0] host_idx,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_idx,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Storage update: software write first, engine write overrides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (host_we) mem[host_idx] <= host_wdata;
            if (eng_we)  mem[eng_idx]  <= eng_wdata;
        end
    end

    // Read ports.
    assign host_rdata = mem[host_idx];
    assign eng_rdata  = mem[eng_idx];

endmodule

// File: rtl/smb_buf_index.sv
// Auto-incrementing buffer index shared by reads and writes of the block
// data register. Clear has priority over a step in the same cycle.
module smb_buf_index #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // Index register: clear, wrap after the last entry, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n)           idx <= '0;
        else if (clr)         idx <= '0;
        else if (step)        idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && idx == LAST) |=> (idx == '0)); // R8
    AST_IDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (idx == '0)); // R9

endmodule

// File: rtl/smb_txn_ctrl.sv
// Transaction launch control: decides whether a start launches, flags an
// invalid protocol code, and holds the request until the engine acknowledges.
// Assumes eng_ack is a single-cycle pulse; an ack with no request is ignored.
module smb_txn_ctrl
    import smb_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] code,
    input  logic       eng_ack,
    output logic       busy,
    output logic       launch,
    output logic       bad_code,
    output logic       finish
);

    // Launch decode: starts while busy are dropped entirely.
    assign launch   = start && !busy && proto_ok(code);
    assign bad_code = start && !busy && !proto_ok(code);
    assign finish   = busy && eng_ack;

    // Busy flag: set on launch, cleared on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (finish) busy <= 1'b0;
        else if (launch) busy <= 1'b1;
    end

    AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |=> !busy); // R5
    AST_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy); // R4
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_ack) |=> busy); // R3

endmodule

// File: rtl/smb_host_regs.sv
// SMBus host register front end (top). Decodes the byte register window,
// launches one engine request per valid start, freezes the transfer
// arguments for the request lifetime and collects completion data.
// Assumes reg_wr and reg_rd are never both high and that the engine keeps
// eng_ack low when no request is pending.
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 32,
    localparam int unsigned IW       = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [5:0]    reg_ofs,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          eng_req,
    output logic [2:0]    eng_proto,
    output logic          eng_rnw,
    output logic [6:0]    eng_taddr,
    output logic [7:0]    eng_cmd,
    output logic [7:0]    eng_d0,
    output logic [7:0]    eng_d1,
    input  logic          eng_ack,
    input  logic          eng_err,
    input  logic [7:0]    eng_rd0,
    input  logic [7:0]    eng_rd1,
    input  logic [IW-1:0] eng_buf_idx,
    input  logic          eng_buf_we,
    input  logic [7:0]    eng_buf_wdata,
    output logic [7:0]    eng_buf_rdata
);

    logic [4:0] ctl_q;
    logic [7:0] cmd_q, tadr_q, d0_q, d1_q;
    logic       done_q, err_q;
    logic       busy, launch, bad_code, finish;
    logic [IW-1:0] idx;
    logic [7:0] blk_rdata;

    // Access decode.
    logic wr_stat, wr_ctl, rd_ctl, blk_acc, blk_wr, start;
    assign wr_stat = reg_wr && (reg_ofs == OFS_STAT);
    assign wr_ctl  = reg_wr && (reg_ofs == OFS_CTRL);
    assign rd_ctl  = reg_rd && (reg_ofs == OFS_CTRL);
    assign blk_wr  = reg_wr && (reg_ofs == OFS_BLK);
    assign blk_acc = (reg_wr || reg_rd) && (reg_ofs == OFS_BLK);
    assign start   = wr_ctl && reg_wdata[6];

    smb_txn_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .code     (reg_wdata[4:2]),
        .eng_ack  (eng_ack),
        .busy     (busy),
        .launch   (launch),
        .bad_code (bad_code),
        .finish   (finish)
    );

    smb_buf_index #(.DEPTH(BUF_DEPTH)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_stat || rd_ctl),
        .step  (blk_acc),
        .idx   (idx)
    );

    smb_blk_buf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (blk_wr),
        .host_idx   (idx),
        .host_wdata (reg_wdata),
        .host_rdata (blk_rdata),
        .eng_we     (eng_buf_we),
        .eng_idx    (eng_buf_idx),
        .eng_wdata  (eng_buf_wdata),
        .eng_rdata  (eng_buf_rdata)
    );

    // Software-written registers and completion write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            cmd_q  <= '0;
            tadr_q <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else begin
            if (wr_ctl)                          ctl_q  <= reg_wdata[4:0];
            if (reg_wr && reg_ofs == OFS_CMD)    cmd_q  <= reg_wdata;
            if (reg_wr && reg_ofs == OFS_TADR)   tadr_q <= reg_wdata;
            if (reg_wr && reg_ofs == OFS_D0)     d0_q   <= reg_wdata;
            if (reg_wr && reg_ofs == OFS_D1)     d1_q   <= reg_wdata;
            if (finish && eng_rnw && !eng_err && proto_returns(eng_proto)) begin
                d0_q <= eng_rd0;
                if (eng_proto == PC_WORD) d1_q <= eng_rd1;
            end
        end
    end

    // Status flags: a status write clears, events set afterwards win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_stat) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (bad_code)            err_q  <= 1'b1;
            if (finish && eng_err)   err_q  <= 1'b1;
            if (finish && !eng_err)  done_q <= 1'b1;
        end
    end

    // Argument snapshot taken at launch and held for the request lifetime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_proto <= '0;
            eng_rnw   <= 1'b0;
            eng_taddr <= '0;
            eng_cmd   <= '0;
            eng_d0    <= '0;
            eng_d1    <= '0;
        end else if (launch) begin
            eng_proto <= reg_wdata[4:2];
            eng_rnw   <= tadr_q[0];
            eng_taddr <= tadr_q[7:1];
            eng_cmd   <= cmd_q;
            eng_d0    <= d0_q;
            eng_d1    <= d1_q;
        end
    end

    assign eng_req = busy;

    // Read data multiplexer.
    always_comb begin
        unique case (reg_ofs)
            OFS_STAT: reg_rdata = {5'b0, err_q, done_q, busy};
            OFS_CTRL: reg_rdata = {3'b0, ctl_q};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_TADR: reg_rdata = tadr_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            OFS_BLK:  reg_rdata = blk_rdata;
            default:  reg_rdata = 8'h00;
        endcase
    end

    AST_ARGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=>
        $stable({eng_proto, eng_rnw, eng_taddr, eng_cmd, eng_d0, eng_d1})); // R6
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(reg_wr && reg_ofs == OFS_CTRL && reg_wdata[6])); // R3
    AST_DONE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_ack && !eng_err && !wr_stat) |=> reg_ofs != OFS_STAT || reg_rdata[1]); // R4

endmodule

// File: tb/smb_host_regs_tb.sv
// Directed bench for smb_host_regs: one task per scenario, engine modelled inline.
module smb_host_regs_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0] reg_ofs = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_rnw;
    logic [2:0] eng_proto;
    logic [6:0] eng_taddr;
    logic [7:0] eng_cmd, eng_d0, eng_d1;
    logic       eng_ack = 1'b0, eng_err = 1'b0;
    logic [7:0] eng_rd0 = '0, eng_rd1 = '0;
    logic [4:0] eng_buf_idx = '0;
    logic       eng_buf_we = 1'b0;
    logic [7:0] eng_buf_wdata = '0;
    logic [7:0] eng_buf_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smb_host_regs u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_ofs = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_ofs = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic ack(input logic [7:0] r0, input logic [7:0] r1, input logic e);
        @(negedge clk); eng_ack = 1'b1; eng_rd0 = r0; eng_rd1 = r1; eng_err = e;
        @(negedge clk); eng_ack = 1'b0; eng_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 eng_req", eng_req, 0);
        rd(0, v); chk("R1 status", v, 0);
        rd(2, v); chk("R1 control", v, 0);
        rd(5, v); chk("R1 data0", v, 0);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3, 8'h12); wr(4, 8'hA0); wr(5, 8'h34); wr(6, 8'h56);
        rd(3, v); chk("R2 command", v, 8'h12);
        rd(4, v); chk("R2 address", v, 8'hA0);
        rd(5, v); chk("R2 data0", v, 8'h34);
        rd(6, v); chk("R2 data1", v, 8'h56);
        rd(1, v); chk("R2 offset1", v, 0);
        rd(6'h2A, v); chk("R2 offset2A", v, 0);
    endtask

    task automatic t_word_write();
        logic [7:0] v;
        wr(2, 8'h4C);
        chk("R3 req", eng_req, 1);
        chk("R3 proto", eng_proto, 3);
        chk("R3 rnw", eng_rnw, 0);
        chk("R3 taddr", eng_taddr, 7'h50);
        chk("R3 cmd", eng_cmd, 8'h12);
        chk("R3 d0", eng_d0, 8'h34);
        chk("R3 d1", eng_d1, 8'h56);
        rd(0, v); chk("R4 busy", v, 8'h01);
        wr(2, 8'h40);
        chk("R6 proto held", eng_proto, 3);
        chk("R6 req held", eng_req, 1);
        ack(8'hEE, 8'hFF, 1'b0);
        chk("R6 no relaunch", eng_req, 0);
        rd(0, v); chk("R4 done", v, 8'h02);
        rd(5, v); chk("R7 write keeps d0", v, 8'h34);
        rd(6, v); chk("R7 write keeps d1", v, 8'h56);
    endtask

    task automatic t_word_read();
        logic [7:0] v;
        wr(0, 0); rd(0, v); chk("R9 status cleared", v, 0);
        wr(4, 8'hA1); wr(2, 8'h4C);
        chk("R3 read rnw", eng_rnw, 1);
        ack(8'hCD, 8'hAB, 1'b0);
        rd(5, v); chk("R7 word d0", v, 8'hCD);
        rd(6, v); chk("R7 word d1", v, 8'hAB);
    endtask

    task automatic t_recv_byte();
        logic [7:0] v;
        wr(0, 0); wr(4, 8'h31); wr(2, 8'h44);
        chk("R3 byte proto", eng_proto, 1);
        ack(8'h77, 8'h99, 1'b0);
        rd(5, v); chk("R7 recv d0", v, 8'h77);
        rd(6, v); chk("R7 recv keeps d1", v, 8'hAB);
    endtask

    task automatic t_eng_err();
        logic [7:0] v;
        wr(0, 0); wr(2, 8'h40);
        chk("R3 quick req", eng_req, 1);
        ack(8'h00, 8'h00, 1'b1);
        rd(0, v); chk("R4 error", v, 8'h04);
    endtask

    task automatic t_bad_code();
        logic [7:0] v;
        wr(0, 0); wr(2, 8'h50);
        chk("R5 no req", eng_req, 0);
        rd(0, v); chk("R5 error bit", v, 8'h04);
        wr(0, 0); wr(2, 8'h5C);
        chk("R5 code7 no req", eng_req, 0);
    endtask

    task automatic t_block_write();
        wr(0, 0);
        wr(7, 8'h11); wr(7, 8'h22); wr(7, 8'h33);
        wr(5, 8'h03); wr(4, 8'hA0); wr(2, 8'h54);
        chk("R3 block proto", eng_proto, 5);
        chk("R3 block count", eng_d0, 3);
        eng_buf_idx = 5'd1; #1;
        chk("R8 engine reads entry1", eng_buf_rdata, 8'h22);
        eng_buf_idx = 5'd2; #1;
        chk("R8 engine reads entry2", eng_buf_rdata, 8'h33);
        ack(8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_block_read();
        logic [7:0] v;
        wr(0, 0); wr(4, 8'hA1); wr(2, 8'h54);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); eng_buf_we = 1'b1; eng_buf_idx = 5'(i); eng_buf_wdata = 8'hA0 + 8'(i);
        end
        @(negedge clk); eng_buf_we = 1'b0;
        ack(8'h04, 8'h00, 1'b0);
        rd(5, v); chk("R7 block count", v, 4);
        wr(0, 0);
        for (int i = 0; i < 4; i++) begin
            rd(7, v); chk("R8 block read entry", v, 8'hA0 + 8'(i));
        end
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        wr(0, 0);
        for (int i = 0; i < 33; i++) wr(7, 8'(i));
        wr(0, 0);
        rd(7, v); chk("R8 wrap entry0", v, 8'd32);
        rd(7, v); chk("R8 wrap entry1", v, 8'd1);
    endtask

    task automatic t_ctl_read_idx();
        logic [7:0] v;
        wr(0, 0); wr(7, 8'hE1); wr(7, 8'hE2);
        rd(2, v); chk("R9 control low bits", v, 8'h14);
        wr(7, 8'hEE);
        eng_buf_idx = 5'd0; #1;
        chk("R9 index reset by control read", eng_buf_rdata, 8'hEE);
        eng_buf_idx = 5'd1; #1;
        chk("R9 entry1 kept", eng_buf_rdata, 8'hE2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_word_write();
        t_word_read();
        t_recv_byte();
        t_eng_err();
        t_bad_code();
        t_block_write();
        t_block_read();
        t_wrap();
        t_ctl_read_idx();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule